// File: doc/BRIEF.md
# Modem Control and Status Block

This block sits inside a serial port. It holds the five-bit modem control register and the eight-bit modem status register. Four modem input lines (clear-to-send, data-set-ready, carrier detect and ring) pass through a synchronizer and are then compared each cycle against the stored line state. Every change records a sticky change flag in the low half of the status register. When the ring line goes from high to low, a trailing-edge ring flag is recorded. While any change flag is set, a single pending output is raised so that an interrupt controller elsewhere can act on it.

A host writes the control register and reads both registers through a small register port. When the host reads the status register, it gets the current value, and the change flags are cleared at that clock edge. A change that is detected on the same edge is kept. When the loop bit of the control register is set, the status register reads a fixed remapping of the control outputs instead of the real lines, with a zero low half. A read in this mode does not disturb the stored change flags.

Top module: `modem_status_unit`

## Requirements
- R1: After synchronous reset, the status register reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control register reads 0x08 (OUT2 set), and `delta_pend` is 0.
- R2: A control write keeps bits 4:0 of the data: DTR=bit0, RTS=bit1, OUT1=bit2, OUT2=bit3, LOOP=bit4. The register reads back with bits 7:5 zero. The four output pins follow bits 3:0.
- R3: Status bits 7:4 hold DCD=7, RI=6, DSR=5, CTS=4. A change on an input pin appears in the status read exactly SYNC_STAGES+1 clock edges after it is applied, and not one edge earlier.
- R4: A toggle of CTS, DSR or DCD sets DCTS (bit 0), DDSR (bit 1) or DDCD (bit 3) respectively. The flags accumulate by OR and stay set until cleared.
- R5: TERI (bit 2) is set only when RI falls from 1 to 0. A rising RI sets no change flag.
- R6: A status read returns the value before clearing, and bits 3:0 are zero afterwards. A read of the control register leaves the change flags untouched.
- R7: A line change detected on the same edge as a clearing status read is kept as a change flag after that edge.
- R8: `delta_pend` is 1 exactly when at least one of status bits 3:0 is set.
- R9: With LOOP set, a status read returns OUT2 on bit 7, OUT1 on bit 6, DTR on bit 5, RTS on bit 4 and zeros on bits 3:0. Such a read does not clear the stored change flags, which are visible again once LOOP is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Write data for the control register |
| rd_en | input | 1 | Read strobe; with `rd_sel`=1 it clears the change flags |
| rd_sel | input | 1 | Read select: 0 control register, 1 status register |
| rd_data | output | 8 | Combinational read data of the selected register |
| cts_in | input | 1 | Clear-to-send line |
| dsr_in | input | 1 | Data-set-ready line |
| dcd_in | input | 1 | Carrier-detect line |
| ri_in | input | 1 | Ring line |
| dtr_out | output | 1 | Data-terminal-ready output (control bit 0) |
| rts_out | output | 1 | Request-to-send output (control bit 1) |
| out1_out | output | 1 | General output 1 (control bit 2) |
| out2_out | output | 1 | General output 2 (control bit 3) |
| delta_pend | output | 1 | High while any change flag is set |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default 2. A latency that is accidentally fixed at the default depth therefore shows up as a wrong read one edge early or late. Each input change is sampled both on the edge before it may appear and on the edge where it must appear. Because the latency is known exactly, the bench can line up a line change with a clearing status read on the same edge, which is the case R7 covers.

// File: rtl/modem_pkg.sv
package modem_pkg;

    localparam int REG_W = 8;
    localparam int CTL_W = 5;
    localparam int LINE_W = 4;

    // Line state, packed so that it lands on status bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    // Change flags, packed so that they land on status bits 3:0
    typedef struct packed {
        logic dcd_chg;
        logic ri_trail;
        logic dsr_chg;
        logic cts_chg;
    } mdm_delta_t;

    // Control register, bit 4 down to bit 0
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mdm_ctl_t;

    typedef enum logic {
        SEL_CTL  = 1'b0,
        SEL_STAT = 1'b1
    } mdm_sel_e;

    localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam mdm_ctl_t   CTL_RST   = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
    localparam mdm_delta_t DELTA_NONE = '{dcd_chg: 1'b0, ri_trail: 1'b0, dsr_chg: 1'b0, cts_chg: 1'b0};

    // Fixed wiring of control outputs back onto line inputs in loop mode
    function automatic mdm_lines_t loop_view(input mdm_ctl_t c);
        mdm_lines_t v;
        v.dcd = c.out2;
        v.ri  = c.out1;
        v.dsr = c.dtr;
        v.cts = c.rts;
        return v;
    endfunction

    // Events between the stored and the freshly sampled line state
    function automatic mdm_delta_t line_events(input mdm_lines_t prev, input mdm_lines_t cur);
        mdm_delta_t e;
        e.dcd_chg  = prev.dcd ^ cur.dcd;
        e.dsr_chg  = prev.dsr ^ cur.dsr;
        e.cts_chg  = prev.cts ^ cur.cts;
        e.ri_trail = prev.ri & ~cur.ri;
        return e;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input mdm_lines_t l, input mdm_delta_t d);
        return {l, d};
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input mdm_ctl_t c);
        return {{(REG_W-CTL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output mdm_ctl_t         ctl_o
);
    mdm_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RST;
        end else if (wr_en_i) begin
            ctl_q <= mdm_ctl_t'(wr_data_i);
        end
    end

    assign ctl_o = ctl_q;

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (ctl_q == mdm_ctl_t'($past(wr_data_i))));

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(ctl_q));
endmodule

// File: rtl/modem_delta_track.sv
module modem_delta_track
    import modem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mdm_lines_t smp_i,
    input  logic       clr_i,
    output mdm_lines_t lines_o,
    output mdm_delta_t delta_o
);
    mdm_lines_t lines_q;
    mdm_delta_t delta_q;
    mdm_delta_t evt;
    mdm_delta_t delta_d;

    always_comb begin
        evt     = line_events(lines_q, smp_i);
        delta_d = (clr_i ? DELTA_NONE : delta_q) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= LINES_RST;
            delta_q <= DELTA_NONE;
        end else begin
            lines_q <= smp_i;
            delta_q <= delta_d;
        end
    end

    assign lines_o = lines_q;
    assign delta_o = delta_q;

    // R3
    line_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lines_q) |-> ($past(smp_i) != $past(lines_q)));

    // R4
    delta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R5
    teri_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_q.ri_trail) |-> ($past(lines_q.ri) && !lines_q.ri));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (smp_i == lines_q)) |=> (delta_q == DELTA_NONE));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr_en,
    input  logic [7:0] ctl_wr_data,
    input  logic       rd_en,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       dcd_in,
    input  logic       ri_in,
    output logic       dtr_out,
    output logic       rts_out,
    output logic       out1_out,
    output logic       out2_out,
    output logic       delta_pend
);
    mdm_ctl_t   ctl;
    mdm_lines_t pins;
    mdm_lines_t smp;
    mdm_lines_t lines;
    mdm_delta_t delta;
    mdm_sel_e   sel;
    logic       clr;
    logic [REG_W-1:0] stat_view;
    logic       unused_wr_hi;

    assign unused_wr_hi = ^ctl_wr_data[REG_W-1:CTL_W];

    assign pins = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};

    modem_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINES_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(pins),
        .q_o(smp)
    );

    modem_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (ctl_wr_en),
        .wr_data_i(ctl_wr_data[CTL_W-1:0]),
        .ctl_o    (ctl)
    );

    modem_delta_track u_track (
        .clk    (clk),
        .rst    (rst),
        .smp_i  (smp),
        .clr_i  (clr),
        .lines_o(lines),
        .delta_o(delta)
    );

    assign sel = mdm_sel_e'(rd_sel);
    assign clr = rd_en && (sel == SEL_STAT) && !ctl.loop;

    always_comb begin
        if (ctl.loop) begin
            stat_view = pack_status(loop_view(ctl), DELTA_NONE);
        end else begin
            stat_view = pack_status(lines, delta);
        end
        rd_data = (sel == SEL_STAT) ? stat_view : pack_ctl(ctl);
    end

    assign dtr_out    = ctl.dtr;
    assign rts_out    = ctl.rts;
    assign out1_out   = ctl.out1;
    assign out2_out   = ctl.out2;
    assign delta_pend = |delta;

    // R8
    pend_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_pend) |-> !$stable(lines));

    // R9
    loop_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.loop && sel == SEL_STAT) |-> (rd_data[3:0] == 4'h0));

    // R9
    loop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_STAT && ctl.loop) |=> ((delta & $past(delta)) == $past(delta)));
endmodule

// File: tb/modem_status_unit_tb.sv
module modem_status_unit_tb;
    localparam int STAGES = 3;
    localparam int LAT = STAGES + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
    logic       dtr_out, rts_out, out1_out, out2_out, delta_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    modem_status_unit #(.SYNC_STAGES(STAGES)) u_dut (
        .clk(clk), .rst(rst),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
        .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out),
        .delta_pend(delta_pend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b0;
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (LAT) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(1'b1, v); chk("R1 status", v, 8'hB0);
        peek(1'b0, v); chk("R1 control", v, 8'h08);
        chk("R1 pend", {7'b0, delta_pend}, 8'h00);
        chk("R1 pins", {4'b0, out2_out, out1_out, rts_out, dtr_out}, 8'h08);
    endtask

    task automatic t_ctl();
        logic [7:0] v;
        write_ctl(8'hFF);
        peek(1'b0, v); chk("R2 mask", v, 8'h1F);
        chk("R2 pins all", {4'b0, out2_out, out1_out, rts_out, dtr_out}, 8'h0F);
        write_ctl(8'hEA);
        peek(1'b0, v); chk("R2 readback", v, 8'h0A);
        chk("R2 pins", {4'b0, out2_out, out1_out, rts_out, dtr_out}, 8'h0A);
        write_ctl(8'h08);
    endtask

    task automatic t_cts();
        logic [7:0] v;
        @(negedge clk); cts_in = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        peek(1'b1, v); chk("R3 early", v, 8'hB0);
        @(posedge clk);
        peek(1'b1, v); chk("R3 R4 cts", v, 8'hA1);
        chk("R8 pend set", {7'b0, delta_pend}, 8'h01);
        read_reg(1'b1, v); chk("R6 read value", v, 8'hA1);
        peek(1'b1, v); chk("R6 cleared", v, 8'hA0);
        chk("R8 pend clear", {7'b0, delta_pend}, 8'h00);
    endtask

    task automatic t_accum();
        logic [7:0] v;
        @(negedge clk); dsr_in = 1'b0;
        settle();
        @(negedge clk); dcd_in = 1'b0;
        settle();
        peek(1'b1, v); chk("R4 accumulate", v, 8'h0A);
        read_reg(1'b1, v); chk("R6 read accum", v, 8'h0A);
        peek(1'b1, v); chk("R6 accum clear", v, 8'h00);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        @(negedge clk); ri_in = 1'b1;
        settle();
        peek(1'b1, v); chk("R5 rising ring", v, 8'h40);
        chk("R5 R8 no pend", {7'b0, delta_pend}, 8'h00);
        @(negedge clk); ri_in = 1'b0;
        settle();
        peek(1'b1, v); chk("R5 falling ring", v, 8'h04);
        chk("R8 pend ring", {7'b0, delta_pend}, 8'h01);
        read_reg(1'b1, v);
        peek(1'b1, v); chk("R6 ring clear", v, 8'h00);
    endtask

    task automatic t_ctl_read();
        logic [7:0] v;
        @(negedge clk); cts_in = 1'b1;
        settle();
        read_reg(1'b0, v); chk("R6 ctl read", v, 8'h08);
        peek(1'b1, v); chk("R6 ctl read keeps flags", v, 8'h11);
        read_reg(1'b1, v);
        peek(1'b1, v); chk("R6 clear", v, 8'h10);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        @(negedge clk); dsr_in = 1'b1;
        repeat (LAT - 1) @(posedge clk);
        read_reg(1'b1, v); chk("R7 read before event", v, 8'h10);
        peek(1'b1, v); chk("R7 event kept", v, 8'h32);
        read_reg(1'b1, v);
        peek(1'b1, v); chk("R7 cleared later", v, 8'h30);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        @(negedge clk); dcd_in = 1'b1;
        settle();
        peek(1'b1, v); chk("R4 carrier", v, 8'hB8);
        write_ctl(8'h19);
        peek(1'b1, v); chk("R9 loop view a", v, 8'hA0);
        read_reg(1'b1, v); chk("R9 loop read", v, 8'hA0);
        chk("R9 pend kept", {7'b0, delta_pend}, 8'h01);
        write_ctl(8'h16);
        peek(1'b1, v); chk("R9 loop view b", v, 8'h50);
        write_ctl(8'h08);
        peek(1'b1, v); chk("R9 flags kept", v, 8'hB8);
        read_reg(1'b1, v);
        peek(1'b1, v); chk("R6 final clear", v, 8'hB0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_ctl();
        t_cts();
        t_accum();
        t_ring();
        t_ctl_read();
        t_collide();
        t_loop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule